// File: doc/BRIEF.md
# Dual-Port Burst-Counter Synchronous RAM

This block is a true dual-port synchronous memory. Each word is 18 bits wide, split into two 9-bit byte lanes. Two ports, called A and B, can read or write any location in the same cycle, including the same location. Each port registers its address, write data and controls on the rising clock edge. Each port also has an internal address counter. The counter can be cleared, loaded from the address pins, or stepped by one. This lets a port run a burst after giving only the start address.

Each port has its own latency select. In flow-through mode, read data appears in the cycle after the capture edge. In pipelined mode, data passes through one more output register. A port is selected only when its active-low select is low and its active-high select is high. Because of this, two devices can be stacked for depth without an external decoder. An active-low output enable blanks the read result.

The port address is 13 bits wide. The array depth is set by a separate parameter. The default build holds 4096 words and ignores the top address bit.

Both ports share one clock. This fixes the outcome of every same-cycle collision.

Top module: `dpbc_ram`

## Requirements
- R1: After reset, `a_rvalid` and `b_rvalid` are 0 and both address counters are 0. A write issued with no load and no step lands at address 0.
- R2: A port is selected only when its `_sel_n` is 0 and its `_sel` is 1. A deselected port does not write, and its `_rvalid` stays 0.
- R3: On a clock edge, a low `_clr_n` sets the port address to 0. This takes priority over load and step.
- R4: If `_clr_n` is high and `_load_n` is low, the port address is loaded from `_addr`. This takes priority over step.
- R5: If only `_step_n` is low, the port address increments by one and wraps from 13'h1FFF to 0. With none of the three low, the address holds.
- R6: With `_pipe` = 0 (flow-through), read data and valid flags appear in the cycle after the edge that captured the read.
- R7: With `_pipe` = 1 (pipelined), the same result appears one cycle later, and valid is 0 in the cycle before.
- R8: Lane 0 is bits 8:0 and is enabled by `_lane_n[0]` = 0. Lane 1 is bits 17:9 and is enabled by `_lane_n[1]` = 0. A write changes only the enabled lanes. A read raises `_rvalid[i]` only for enabled lanes and returns 0 on disabled lanes.
- R9: When `_oe_n` is 1, `_rvalid` is 0 and `_rdata` is 0.
- R10: If both ports write the same word in one cycle, port B's data wins on lanes that both ports enable. Each other enabled lane takes the data of the port that enabled it.
- R11: A read on one port of the word the other port writes in the same cycle returns the old contents.
- R12: The array is indexed by the low `ARRAY_AW` bits of the port address. With the default of 12, address 13'h1005 and address 13'h0005 are the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel_n | input | 1 | Port A select, active low |
| a_sel | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A: 0 = write, 1 = read |
| a_lane_n | input | 2 | Port A byte-lane enables, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_pipe | input | 1 | Port A latency: 0 = flow-through, 1 = pipelined |
| a_load_n | input | 1 | Port A load counter from address, active low |
| a_step_n | input | 1 | Port A increment counter, active low |
| a_clr_n | input | 1 | Port A clear counter, active low |
| a_addr | input | 13 | Port A external address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data |
| a_rvalid | output | 2 | Port A per-lane read valid |
| b_sel_n | input | 1 | Port B select, active low |
| b_sel | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B: 0 = write, 1 = read |
| b_lane_n | input | 2 | Port B byte-lane enables, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_pipe | input | 1 | Port B latency: 0 = flow-through, 1 = pipelined |
| b_load_n | input | 1 | Port B load counter from address, active low |
| b_step_n | input | 1 | Port B increment counter, active low |
| b_clr_n | input | 1 | Port B clear counter, active low |
| b_addr | input | 13 | Port B external address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data |
| b_rvalid | output | 2 | Port B per-lane read valid |

## Verification
The pipelined-latency property assumes that `_pipe` and `_oe_n` are steady for at least one cycle before the result is observed. The stimulus changes a port's mode only while that port is idle, and it holds `_oe_n` across each read. The collision property assumes that both ports run on the one shared clock and that their controls settle away from the rising edge. The bench therefore drives every input on the falling edge. All inputs are held at defined values from time zero, so no property sees an unknown control after reset.

// File: rtl/dpbc_pkg.sv
package dpbc_pkg;
    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } lat_mode_e;
endpackage

// File: rtl/dpbc_port_ctrl.sv
module dpbc_port_ctrl #(
    parameter int AW     = 13,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    sel,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    load_n,
    input  logic                    step_n,
    input  logic                    clr_n,
    input  logic [AW-1:0]           ext_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [AW-1:0]           acc_addr,
    output logic                    acc_rd,
    output logic                    acc_wr,
    output logic [LANES-1:0]        acc_lanes,
    output logic [LANES*LANE_W-1:0] acc_wdata
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic             sel;
        logic             wr;
        logic [LANES-1:0] lanes;
        logic [DW-1:0]    wdata;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d = req_q;
        // Address source priority: clear, then load, then step, else hold.
        if (!clr_n) begin
            req_d.addr = '0;
        end else if (!load_n) begin
            req_d.addr = ext_addr;
        end else if (!step_n) begin
            req_d.addr = req_q.addr + AW'(1);
        end
        req_d.sel   = !sel_n && sel;
        req_d.wr    = !wr_n;
        req_d.lanes = ~lane_n;
        req_d.wdata = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign acc_addr  = req_q.addr;
    assign acc_rd    = req_q.sel && !req_q.wr;
    assign acc_wr    = req_q.sel && req_q.wr;
    assign acc_lanes = req_q.lanes;
    assign acc_wdata = req_q.wdata;

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (acc_addr == '0));
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !load_n) |=> (acc_addr == $past(ext_addr)));
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n && !step_n) |=> (acc_addr == $past(acc_addr) + AW'(1)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n && step_n) |=> $stable(acc_addr));
    p_unsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !sel) |=> (!acc_wr && !acc_rd));
endmodule

// File: rtl/dpbc_array.sv
module dpbc_array #(
    parameter int AW     = 13,
    parameter int IDX_W  = 12,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           a_addr,
    input  logic                    a_wr,
    input  logic [LANES-1:0]        a_lanes,
    input  logic [LANES*LANE_W-1:0] a_wdata,
    input  logic [AW-1:0]           b_addr,
    input  logic                    b_wr,
    input  logic [LANES-1:0]        b_lanes,
    input  logic [LANES*LANE_W-1:0] b_wdata,
    output logic [LANES*LANE_W-1:0] a_rdata,
    output logic [LANES*LANE_W-1:0] b_rdata
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0]    mem [DEPTH];
    logic [IDX_W-1:0] a_idx, b_idx;
    logic [DW-1:0]    b_mask;

    assign a_idx = a_addr[IDX_W-1:0];
    assign b_idx = b_addr[IDX_W-1:0];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            b_mask[i*LANE_W +: LANE_W] = {LANE_W{b_lanes[i]}};
        end
    end

    // Port B's lane write comes later in program order, so it wins a tie.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (a_wr && a_lanes[i]) begin
                mem[a_idx][i*LANE_W +: LANE_W] <= a_wdata[i*LANE_W +: LANE_W];
            end
            if (b_wr && b_lanes[i]) begin
                mem[b_idx][i*LANE_W +: LANE_W] <= b_wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    // Reads see the array before this cycle's writes commit.
    assign a_rdata = mem[a_idx];
    assign b_rdata = mem[b_idx];

    p_bwins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && b_wr && (a_idx == b_idx)) |=>
        ((mem[$past(b_idx)] & $past(b_mask)) == ($past(b_wdata) & $past(b_mask))));
endmodule

// File: rtl/dpbc_rd_out.sv
module dpbc_rd_out
    import dpbc_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  lat_mode_e               mode,
    input  logic                    oe_n,
    input  logic                    rd_en,
    input  logic [LANES-1:0]        lanes,
    input  logic [LANES*LANE_W-1:0] raw,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        rvalid
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic [DW-1:0]    data;
        logic [LANES-1:0] lanes;
    } stage_t;

    stage_t flow, stage_d, stage_q, pick;

    always_comb begin
        flow.data  = raw;
        flow.lanes = rd_en ? lanes : '0;
        stage_d    = flow;
        pick       = (mode == LAT_PIPE) ? stage_q : flow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign rvalid = pick.lanes & {LANES{!oe_n}};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] =
            rvalid[g] ? pick.data[g*LANE_W +: LANE_W] : '0;
    end

    p_pipe_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LAT_PIPE && !oe_n) |-> (rvalid == $past(flow.lanes)));
endmodule

// File: rtl/dpbc_ram.sv
module dpbc_ram
    import dpbc_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int ARRAY_AW = 12,
    parameter int LANES    = 2,
    parameter int LANE_W   = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    a_sel_n,
    input  logic                    a_sel,
    input  logic                    a_wr_n,
    input  logic [LANES-1:0]        a_lane_n,
    input  logic                    a_oe_n,
    input  logic                    a_pipe,
    input  logic                    a_load_n,
    input  logic                    a_step_n,
    input  logic                    a_clr_n,
    input  logic [ADDR_W-1:0]       a_addr,
    input  logic [LANES*LANE_W-1:0] a_wdata,
    output logic [LANES*LANE_W-1:0] a_rdata,
    output logic [LANES-1:0]        a_rvalid,
    input  logic                    b_sel_n,
    input  logic                    b_sel,
    input  logic                    b_wr_n,
    input  logic [LANES-1:0]        b_lane_n,
    input  logic                    b_oe_n,
    input  logic                    b_pipe,
    input  logic                    b_load_n,
    input  logic                    b_step_n,
    input  logic                    b_clr_n,
    input  logic [ADDR_W-1:0]       b_addr,
    input  logic [LANES*LANE_W-1:0] b_wdata,
    output logic [LANES*LANE_W-1:0] b_rdata,
    output logic [LANES-1:0]        b_rvalid
);
    localparam int DW = LANES * LANE_W;

    logic [ADDR_W-1:0] a_acc_addr, b_acc_addr;
    logic              a_acc_rd, a_acc_wr, b_acc_rd, b_acc_wr;
    logic [LANES-1:0]  a_acc_lanes, b_acc_lanes;
    logic [DW-1:0]     a_acc_wdata, b_acc_wdata, a_raw, b_raw;

    dpbc_port_ctrl #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl_a (
        .clk(clk), .rst_n(rst_n), .sel_n(a_sel_n), .sel(a_sel), .wr_n(a_wr_n),
        .lane_n(a_lane_n), .load_n(a_load_n), .step_n(a_step_n), .clr_n(a_clr_n),
        .ext_addr(a_addr), .wdata(a_wdata), .acc_addr(a_acc_addr),
        .acc_rd(a_acc_rd), .acc_wr(a_acc_wr), .acc_lanes(a_acc_lanes),
        .acc_wdata(a_acc_wdata));

    dpbc_port_ctrl #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl_b (
        .clk(clk), .rst_n(rst_n), .sel_n(b_sel_n), .sel(b_sel), .wr_n(b_wr_n),
        .lane_n(b_lane_n), .load_n(b_load_n), .step_n(b_step_n), .clr_n(b_clr_n),
        .ext_addr(b_addr), .wdata(b_wdata), .acc_addr(b_acc_addr),
        .acc_rd(b_acc_rd), .acc_wr(b_acc_wr), .acc_lanes(b_acc_lanes),
        .acc_wdata(b_acc_wdata));

    dpbc_array #(.AW(ADDR_W), .IDX_W(ARRAY_AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_acc_addr), .a_wr(a_acc_wr), .a_lanes(a_acc_lanes), .a_wdata(a_acc_wdata),
        .b_addr(b_acc_addr), .b_wr(b_acc_wr), .b_lanes(b_acc_lanes), .b_wdata(b_acc_wdata),
        .a_rdata(a_raw), .b_rdata(b_raw));

    dpbc_rd_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out_a (
        .clk(clk), .rst_n(rst_n), .mode(lat_mode_e'(a_pipe)), .oe_n(a_oe_n),
        .rd_en(a_acc_rd), .lanes(a_acc_lanes), .raw(a_raw),
        .rdata(a_rdata), .rvalid(a_rvalid));

    dpbc_rd_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out_b (
        .clk(clk), .rst_n(rst_n), .mode(lat_mode_e'(b_pipe)), .oe_n(b_oe_n),
        .rd_en(b_acc_rd), .lanes(b_acc_lanes), .raw(b_raw),
        .rdata(b_rdata), .rvalid(b_rvalid));
endmodule

// File: tb/dpbc_ram_test.sv
module dpbc_ram_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_sel_n = 1'b1, a_sel = 1'b0, a_wr_n = 1'b1, a_oe_n = 1'b0, a_pipe = 1'b0;
    logic        a_load_n = 1'b1, a_step_n = 1'b1, a_clr_n = 1'b1;
    logic [1:0]  a_lane_n = 2'b00;
    logic [12:0] a_addr = '0;
    logic [17:0] a_wdata = '0;
    logic [17:0] a_rdata;
    logic [1:0]  a_rvalid;
    logic        b_sel_n = 1'b1, b_sel = 1'b0, b_wr_n = 1'b1, b_oe_n = 1'b0, b_pipe = 1'b1;
    logic        b_load_n = 1'b1, b_step_n = 1'b1, b_clr_n = 1'b1;
    logic [1:0]  b_lane_n = 2'b00;
    logic [12:0] b_addr = '0;
    logic [17:0] b_wdata = '0;
    logic [17:0] b_rdata;
    logic [1:0]  b_rvalid;

    logic [17:0] ref_mem [4096];
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    dpbc_ram uut (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_sel(a_sel), .a_wr_n(a_wr_n), .a_lane_n(a_lane_n),
        .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_load_n(a_load_n), .a_step_n(a_step_n),
        .a_clr_n(a_clr_n), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_sel_n(b_sel_n), .b_sel(b_sel), .b_wr_n(b_wr_n), .b_lane_n(b_lane_n),
        .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_load_n(b_load_n), .b_step_n(b_step_n),
        .b_clr_n(b_clr_n), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_port(input bit p, input logic [12:0] ad, input logic ld, input logic st,
                            input logic cl, input logic wn, input logic [1:0] ln,
                            input logic [17:0] wd);
        if (!p) begin
            a_sel_n = 0; a_sel = 1; a_addr = ad; a_load_n = ld; a_step_n = st;
            a_clr_n = cl; a_wr_n = wn; a_lane_n = ln; a_wdata = wd;
        end else begin
            b_sel_n = 0; b_sel = 1; b_addr = ad; b_load_n = ld; b_step_n = st;
            b_clr_n = cl; b_wr_n = wn; b_lane_n = ln; b_wdata = wd;
        end
    endtask

    task automatic idle_port(input bit p);
        if (!p) begin
            a_sel_n = 1; a_sel = 0; a_load_n = 1; a_step_n = 1; a_clr_n = 1; a_wr_n = 1;
        end else begin
            b_sel_n = 1; b_sel = 0; b_load_n = 1; b_step_n = 1; b_clr_n = 1; b_wr_n = 1;
        end
    endtask

    task automatic upd(input logic [12:0] ad, input logic [1:0] ln, input logic [17:0] wd);
        if (!ln[0]) ref_mem[ad[11:0]][8:0]  = wd[8:0];
        if (!ln[1]) ref_mem[ad[11:0]][17:9] = wd[17:9];
    endtask

    task automatic wr(input bit p, input logic [12:0] ad, input logic [1:0] ln,
                      input logic [17:0] wd);
        set_port(p, ad, 0, 1, 1, 0, ln, wd);
        tick();
        idle_port(p);
        upd(ad, ln, wd);
    endtask

    task automatic rd(input bit p, input logic [12:0] ad, input logic [1:0] ln,
                      output logic [17:0] d, output logic [1:0] v);
        set_port(p, ad, 0, 1, 1, 1, ln, '0);
        tick();
        idle_port(p);
        if ((p ? b_pipe : a_pipe) == 1'b1) tick();
        d = p ? b_rdata : a_rdata;
        v = p ? b_rvalid : a_rvalid;
    endtask

    task automatic t_reset();
        logic [17:0] d; logic [1:0] v;
        chk("R1 a_rvalid after reset", a_rvalid, 2'b00);
        chk("R1 b_rvalid after reset", b_rvalid, 2'b00);
        set_port(0, 13'h0ABC, 1, 1, 1, 0, 2'b00, 18'h2A5A5);
        tick();
        idle_port(0);
        upd(13'h0000, 2'b00, 18'h2A5A5);
        rd(1, 13'h0000, 2'b00, d, v);
        chk("R1 counter starts at 0", d, ref_mem[0]);
    endtask

    task automatic t_flow();
        logic [17:0] d; logic [1:0] v;
        a_pipe = 0;
        wr(0, 13'h0010, 2'b00, 18'h12345);
        wr(0, 13'h0011, 2'b00, 18'h3F00F);
        set_port(0, 13'h0010, 0, 1, 1, 1, 2'b00, '0);
        tick();
        idle_port(0);
        chk("R6 flow data next cycle", a_rdata, ref_mem[12'h010]);
        chk("R6 flow valid next cycle", a_rvalid, 2'b11);
        rd(0, 13'h0011, 2'b00, d, v);
        chk("R6 flow second word", d, ref_mem[12'h011]);
    endtask

    task automatic t_pipe();
        b_pipe = 1;
        set_port(1, 13'h0011, 0, 1, 1, 1, 2'b00, '0);
        tick();
        idle_port(1);
        chk("R7 pipe not valid after one edge", b_rvalid, 2'b00);
        tick();
        chk("R7 pipe data after two edges", b_rdata, ref_mem[12'h011]);
        chk("R7 pipe valid after two edges", b_rvalid, 2'b11);
    endtask

    task automatic t_modes_swap();
        logic [17:0] d; logic [1:0] v;
        a_pipe = 1; b_pipe = 0;
        tick();
        rd(0, 13'h0010, 2'b00, d, v);
        chk("R7 port A pipelined read", d, ref_mem[12'h010]);
        rd(1, 13'h0011, 2'b00, d, v);
        chk("R6 port B flow read", d, ref_mem[12'h011]);
        a_pipe = 0; b_pipe = 1;
        tick();
    endtask

    task automatic t_lanes();
        logic [17:0] d; logic [1:0] v;
        wr(0, 13'h0020, 2'b00, 18'h3FFFF);
        wr(0, 13'h0020, 2'b10, 18'h00000);
        rd(1, 13'h0020, 2'b00, d, v);
        chk("R8 lower-only write keeps upper", d, ref_mem[12'h020]);
        wr(1, 13'h0020, 2'b01, 18'h0AA00);
        rd(0, 13'h0020, 2'b00, d, v);
        chk("R8 upper-only write keeps lower", d, ref_mem[12'h020]);
        rd(0, 13'h0020, 2'b01, d, v);
        chk("R8 upper lane read valid", v, 2'b10);
        chk("R8 disabled lower lane reads 0", d, {ref_mem[12'h020][17:9], 9'h000});
    endtask

    task automatic t_oe();
        logic [17:0] d; logic [1:0] v;
        a_oe_n = 1;
        rd(0, 13'h0010, 2'b00, d, v);
        chk("R9 oe high blanks valid", v, 2'b00);
        chk("R9 oe high blanks data", d, 18'h0);
        a_oe_n = 0;
    endtask

    task automatic t_chipsel();
        logic [17:0] d; logic [1:0] v;
        set_port(0, 13'h0010, 0, 1, 1, 0, 2'b00, 18'h11111);
        a_sel_n = 1;
        tick();
        idle_port(0);
        set_port(0, 13'h0010, 0, 1, 1, 0, 2'b00, 18'h22222);
        a_sel = 0;
        tick();
        idle_port(0);
        rd(1, 13'h0010, 2'b00, d, v);
        chk("R2 deselected writes ignored", d, ref_mem[12'h010]);
        set_port(0, 13'h0010, 0, 1, 1, 1, 2'b00, '0);
        a_sel = 0;
        tick();
        idle_port(0);
        chk("R2 deselected read not valid", a_rvalid, 2'b00);
    endtask

    task automatic t_counter();
        logic [17:0] d; logic [1:0] v;
        set_port(0, 13'h1FFE, 0, 1, 1, 0, 2'b00, 18'h10001); tick();
        set_port(0, 13'h0000, 1, 0, 1, 0, 2'b00, 18'h10002); tick();
        set_port(0, 13'h0000, 1, 0, 1, 0, 2'b00, 18'h10003); tick();
        set_port(0, 13'h0000, 1, 1, 1, 0, 2'b00, 18'h10004); tick();
        idle_port(0);
        upd(13'h1FFE, 2'b00, 18'h10001);
        upd(13'h1FFF, 2'b00, 18'h10002);
        upd(13'h0000, 2'b00, 18'h10003);
        upd(13'h0000, 2'b00, 18'h10004);
        rd(1, 13'h1FFE, 2'b00, d, v);
        chk("R4 load start address", d, 18'h10001);
        rd(1, 13'h1FFF, 2'b00, d, v);
        chk("R5 step by one", d, 18'h10002);
        rd(1, 13'h0000, 2'b00, d, v);
        chk("R5 wrap to 0 then hold", d, 18'h10004);
        set_port(0, 13'h0123, 0, 0, 0, 0, 2'b00, 18'h20005); tick();
        set_port(0, 13'h0200, 0, 0, 1, 0, 2'b00, 18'h20006); tick();
        idle_port(0);
        upd(13'h0000, 2'b00, 18'h20005);
        upd(13'h0200, 2'b00, 18'h20006);
        rd(1, 13'h0000, 2'b00, d, v);
        chk("R3 clear beats load", d, 18'h20005);
        rd(1, 13'h0123, 2'b00, d, v);
        chk("R3 loaded address untouched", d, ref_mem[12'h123]);
        rd(1, 13'h0200, 2'b00, d, v);
        chk("R4 load beats step", d, 18'h20006);
    endtask

    task automatic t_collide();
        logic [17:0] d; logic [1:0] v;
        set_port(0, 13'h0040, 0, 1, 1, 0, 2'b00, 18'h15555);
        set_port(1, 13'h0040, 0, 1, 1, 0, 2'b10, 18'h0AAAA);
        tick();
        idle_port(0); idle_port(1);
        upd(13'h0040, 2'b00, 18'h15555);
        upd(13'h0040, 2'b10, 18'h0AAAA);
        rd(0, 13'h0040, 2'b00, d, v);
        chk("R10 lanes split between ports", d, ref_mem[12'h040]);
        set_port(0, 13'h0040, 0, 1, 1, 0, 2'b00, 18'h01234);
        set_port(1, 13'h0040, 0, 1, 1, 0, 2'b00, 18'h3CDEF);
        tick();
        idle_port(0); idle_port(1);
        upd(13'h0040, 2'b00, 18'h01234);
        upd(13'h0040, 2'b00, 18'h3CDEF);
        rd(0, 13'h0040, 2'b00, d, v);
        chk("R10 port B wins full overlap", d, 18'h3CDEF);
    endtask

    task automatic t_rdw();
        logic [17:0] d; logic [1:0] v;
        logic [17:0] old;
        a_pipe = 0;
        wr(0, 13'h0041, 2'b00, 18'h0F0F0);
        old = ref_mem[12'h041];
        set_port(0, 13'h0041, 0, 1, 1, 1, 2'b00, '0);
        set_port(1, 13'h0041, 0, 1, 1, 0, 2'b00, 18'h30303);
        tick();
        idle_port(0); idle_port(1);
        upd(13'h0041, 2'b00, 18'h30303);
        chk("R11 read during other write returns old", a_rdata, old);
        rd(0, 13'h0041, 2'b00, d, v);
        chk("R11 new data after the write", d, 18'h30303);
    endtask

    task automatic t_alias();
        logic [17:0] d; logic [1:0] v;
        wr(0, 13'h1005, 2'b00, 18'h2BEEF);
        rd(1, 13'h0005, 2'b00, d, v);
        chk("R12 top address bit ignored", d, 18'h2BEEF);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_flow();
        t_pipe();
        t_modes_swap();
        t_lanes();
        t_oe();
        t_chipsel();
        t_counter();
        t_collide();
        t_rdw();
        t_alias();
        tick();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule